// File: doc/BRIEF.md
# Cached DRAM Strobe-Cycle Controller

This block is a synchronous model of the control front end of a DRAM that keeps one row in an SRAM cache. A system clock samples the asynchronous active-low strobes through a two-flop synchroniser and then detects their edges. When the row strobe falls, the block fixes the cycle type as read, write or refresh. During read and write cycles it reports whether the row hit the cached row. A read miss loads the whole row from the backing array into the cache. Writes go to the array, and also to the cache copy when they hit.

Each byte lane has its own column strobe. Each column strobe drives a level-sensitive column address latch and gates writes for its lane. An output latch enable can freeze read data on the outputs. Refresh cycles use an internal wrapping row counter and run even while the chip is deselected. Read and write cycles are ignored while the chip is deselected. The storage array is a small register array that is indexed by the low bits of the row and column address.

Top module: `cdram_ctl`

## Requirements
- R1: At a detected falling edge of `row_stb_n`, the cycle type is fixed as follows. If `rfsh_n` is low, the cycle is a refresh. Otherwise, `wsel` high gives a write and `wsel` low gives a read.
- R2: Each refresh cycle increments `rfsh_row` by one, modulo 2^ROW_W. After 2048 refreshes at the default width, the counter returns to its start value. Refresh runs whatever the value of `cs_n`.
- R3: `hit_n` is low during an active read or write cycle when `addr` at the row-strobe fall equals the valid cached tag. It is high on a miss and whenever no read or write cycle is active.
- R4: A read miss loads the whole row into the cache and sets the tag valid, so a later read of the same row hits. A refresh does not change the tag or its valid state.
- R5: The column address latch of a lane follows `addr[COL_SEL-1:0]` while that lane's `col_stb_n` is high. It holds the value present when the strobe went low.
- R6: In a write cycle, byte lane b (`din[8b+7:8b]`) is written only while both `col_stb_n[b]` and `wen_n` are low. The other lanes keep their contents.
- R7: A write that hits the cached row also updates the cache copy, so a following read hit returns the new data.
- R8: The output latch of a lane is transparent while `qhold` is low. It freezes the data while `qhold` and that lane's `col_stb_n` are both high.
- R9: `dq_en` is 1 only during a read cycle while `oen_n` is low. When `dq_en` is 0, `dq` reads 0, which stands for undriven pads.
- R10: While `cs_n` is high, a row-strobe fall that is not a refresh starts no cycle. `hit_n` stays high, `dq_en` stays 0, and neither the array nor the cache tag changes.
- R11: Reset makes the tag invalid, clears `rfsh_row` and the latches, drives `hit_n` high and `dq_en` 0, and keeps the array contents.
- R12: A strobe change made before clock edge k first affects registered outputs at edge k+2: two synchroniser flops, then the edge-detect register. `hit_n` is therefore still high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | BYTES | Active-low column strobe, one per byte lane |
| wen_n | input | 1 | Active-low write enable |
| oen_n | input | 1 | Active-low output enable |
| qhold | input | 1 | Output latch enable (high allows hold) |
| rfsh_n | input | 1 | Active-low refresh select, sampled at row-strobe fall |
| wsel | input | 1 | Write (1) / read (0) select, sampled at row-strobe fall |
| cs_n | input | 1 | Active-low chip select |
| addr | input | ROW_W | Multiplexed row / column address |
| din | input | 8*BYTES | Write data |
| dq | output | 8*BYTES | Read data, 0 while not driven |
| dq_en | output | 1 | Data pad drive enable |
| hit_n | output | 1 | Active-low cache hit indication |
| rfsh_row | output | ROW_W | Next row the refresh counter will use |

## Verification
The hardest cases to reach from the ports are the ones where several held states interact. Examples are a write that lands in the array and the cache at the same time, and a column or output latch that must ignore a changing address while the cycle stays open. The stimulus reaches these by keeping the row strobe low inside a read cycle and moving `addr`, `col_stb_n` and `qhold` one at a time. A separate sequence runs a deselected refresh, then a full counter wrap, and then a read of the cached row, to show that the tag survived.

// File: rtl/cdram_ctl.sv
module cdram_ctl #(
  parameter int ROW_W   = 11,
  parameter int BYTES   = 2,
  parameter int ROW_SEL = 2,
  parameter int COL_SEL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_stb_n,
  input  logic [BYTES-1:0]   col_stb_n,
  input  logic               wen_n,
  input  logic               oen_n,
  input  logic               qhold,
  input  logic               rfsh_n,
  input  logic               wsel,
  input  logic               cs_n,
  input  logic [ROW_W-1:0]   addr,
  input  logic [BYTES*8-1:0] din,
  output logic [BYTES*8-1:0] dq,
  output logic               dq_en,
  output logic               hit_n,
  output logic [ROW_W-1:0]   rfsh_row
);
  localparam int DW = BYTES * 8;
  localparam int NR = 1 << ROW_SEL;
  localparam int NC = 1 << COL_SEL;
  localparam int NS = BYTES + 7;
  localparam logic [NS-1:0] SYNC_RST = {{BYTES{1'b1}}, 7'b1010111};

  typedef enum logic [1:0] {CY_IDLE, CY_READ, CY_WRITE, CY_REFRESH} cyc_t;

  logic [NS-1:0] s1, s2;
  logic          re_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= SYNC_RST;
      s2   <= SYNC_RST;
      re_d <= 1'b1;
    end else begin
      s1   <= {col_stb_n, cs_n, wsel, rfsh_n, qhold, oen_n, wen_n, row_stb_n};
      s2   <= s1;
      re_d <= s2[0];
    end

  logic             re_s, we_s, g_s, qh_s, f_s, wr_s, cs_s;
  logic [BYTES-1:0] cal_s;
  assign {cal_s, cs_s, wr_s, f_s, qh_s, g_s, we_s, re_s} = s2;

  wire re_fall = re_d & ~re_s;
  wire re_rise = ~re_d & re_s;

  wire [ROW_SEL-1:0] a_row = addr[ROW_SEL-1:0];
  wire [COL_SEL-1:0] a_col = addr[COL_SEL-1:0];

  cyc_t               cyc;
  logic [ROW_W-1:0]   tag;
  logic               tag_v;
  logic               hit_q;
  logic [ROW_SEL-1:0] row_q;
  logic [ROW_W-1:0]   rcnt;

  wire match   = tag_v && (tag == addr);
  wire rd_load = re_fall && f_s && !cs_s && !wr_s && !match;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cyc   <= CY_IDLE;
      tag   <= '0;
      tag_v <= 1'b0;
      hit_q <= 1'b0;
      hit_n <= 1'b1;
      row_q <= '0;
      rcnt  <= '0;
    end else if (re_fall) begin
      if (!f_s) begin
        cyc  <= CY_REFRESH;
        rcnt <= rcnt + 1'b1;
      end else if (!cs_s) begin
        cyc   <= wr_s ? CY_WRITE : CY_READ;
        row_q <= a_row;
        hit_q <= match;
        hit_n <= ~match;
        if (rd_load) begin
          tag   <= addr;
          tag_v <= 1'b1;
        end
      end else begin
        cyc <= CY_IDLE;
      end
    end else if (re_rise) begin
      cyc   <= CY_IDLE;
      hit_q <= 1'b0;
      hit_n <= 1'b1;
    end

  assign rfsh_row = rcnt;

  logic [DW-1:0]      mem   [NR][NC];
  logic [DW-1:0]      cline [NC];
  logic [COL_SEL-1:0] col_hold [BYTES];
  logic [COL_SEL-1:0] col_eff  [BYTES];
  logic [DW-1:0]      q_eff, q_hold;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NC; c++)
      if (rd_load) cline[c] <= mem[a_row][c];
    for (int b = 0; b < BYTES; b++)
      if (cyc == CY_WRITE && !we_s && !cal_s[b]) begin
        mem[row_q][col_eff[b]][b*8 +: 8] <= din[b*8 +: 8];
        if (hit_q) cline[col_eff[b]][b*8 +: 8] <= din[b*8 +: 8];
      end
  end

  for (genvar gb = 0; gb < BYTES; gb++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        col_hold[gb]        <= '0;
        q_hold[gb*8 +: 8]   <= '0;
      end else begin
        if (cal_s[gb]) col_hold[gb] <= a_col;
        q_hold[gb*8 +: 8] <= q_eff[gb*8 +: 8];
      end

    assign col_eff[gb] = cal_s[gb] ? a_col : col_hold[gb];
    assign q_eff[gb*8 +: 8] = (qh_s && cal_s[gb]) ? q_hold[gb*8 +: 8]
                                                  : cline[col_eff[gb]][gb*8 +: 8];
  end

  assign dq_en = (cyc == CY_READ) && !g_s;
  assign dq    = dq_en ? q_eff : '0;
endmodule

module cdram_ctl_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_stb_n,
  input logic             oen_n,
  input logic             rfsh_n,
  input logic             cs_n,
  input logic             dq_en,
  input logic             hit_n,
  input logic [ROW_W-1:0] rfsh_row
);
  p_dq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oen_n && $past(oen_n) && $past(oen_n, 2)) |-> !dq_en);

  p_rfsh_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_row != $past(rfsh_row)) |-> (rfsh_row == ROW_W'($past(rfsh_row) + 1'b1)));

  p_rfsh_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_row != $past(rfsh_row)) |-> !$past(rfsh_n, 3));

  p_hit_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_n) |-> (!$past(cs_n, 3) && !$past(row_stb_n, 3)));
endmodule

bind cdram_ctl cdram_ctl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .oen_n(oen_n),
  .rfsh_n(rfsh_n), .cs_n(cs_n), .dq_en(dq_en), .hit_n(hit_n),
  .rfsh_row(rfsh_row)
);

// File: tb/tb_cdram_ctl.sv
`timescale 1ns/1ps
module tb_cdram_ctl;
  localparam int ROW_W = 11;
  localparam int BYTES = 2;
  localparam int DW = BYTES * 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, row_stb_n, wen_n, oen_n, qhold, rfsh_n, wsel, cs_n;
  logic [BYTES-1:0] col_stb_n;
  logic [ROW_W-1:0] addr;
  logic [DW-1:0] din, dq;
  logic dq_en, hit_n;
  logic [ROW_W-1:0] rfsh_row;

  cdram_ctl dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    row_stb_n = 1; col_stb_n = '1; wen_n = 1; oen_n = 1; qhold = 0;
    rfsh_n = 1; wsel = 0; addr = '0; din = '0;
  endtask

  task automatic open_row(bit f, bit w, logic [ROW_W-1:0] row);
    rfsh_n = f; wsel = w; addr = row; row_stb_n = 0;
    step(4);
  endtask

  task automatic close_row();
    row_stb_n = 1; col_stb_n = '1; wen_n = 1; oen_n = 1; qhold = 0; rfsh_n = 1;
    step(4);
  endtask

  task automatic do_write(logic [ROW_W-1:0] row, logic [7:0] col, logic [DW-1:0] d,
                          logic [BYTES-1:0] lanes, output logic h);
    open_row(1, 1, row);
    h = hit_n;
    addr = {3'b0, col}; din = d; col_stb_n = ~lanes; wen_n = 0;
    step(4);
    wen_n = 1; col_stb_n = '1;
    step(4);
    close_row();
  endtask

  task automatic do_read(logic [ROW_W-1:0] row, logic [7:0] col,
                         output logic h, output logic [DW-1:0] d, output logic en);
    open_row(1, 0, row);
    h = hit_n;
    addr = {3'b0, col}; oen_n = 0;
    step(4);
    d = dq; en = dq_en;
    close_row();
  endtask

  task automatic do_refresh();
    open_row(0, 0, '0);
    close_row();
  endtask

  // {write, row, col, data, exp hit_n, exp read data}
  localparam logic [52:0] VEC [8] = '{
    {1'b1, 11'h005, 8'd1, 16'hA1B2, 1'b1, 16'h0000},
    {1'b0, 11'h005, 8'd1, 16'h0000, 1'b1, 16'hA1B2},
    {1'b0, 11'h005, 8'd1, 16'h0000, 1'b0, 16'hA1B2},
    {1'b1, 11'h005, 8'd2, 16'hC3D4, 1'b0, 16'h0000},
    {1'b0, 11'h005, 8'd2, 16'h0000, 1'b0, 16'hC3D4},
    {1'b1, 11'h006, 8'd0, 16'h1234, 1'b1, 16'h0000},
    {1'b0, 11'h006, 8'd0, 16'h0000, 1'b1, 16'h1234},
    {1'b0, 11'h005, 8'd2, 16'h0000, 1'b1, 16'hC3D4}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic h, en;
    logic [DW-1:0] d;
    logic [ROW_W-1:0] r0;
    idle_pins(); cs_n = 0; rst_n = 0;
    step(4);
    rst_n = 1;
    step(2);
    // R11 reset state
    chk(hit_n === 1'b1, "R11 hit_n after reset", hit_n, 1);
    chk(dq_en === 1'b0, "R11 dq_en after reset", dq_en, 0);
    chk(rfsh_row === '0, "R11 rfsh_row after reset", rfsh_row, 0);

    // R1 R3 R4 R6 R7: table
    for (int i = 0; i < 8; i++) begin
      logic [52:0] v;
      v = VEC[i];
      if (v[52]) begin
        do_write(v[51:41], v[40:33], v[32:17], '1, h);
        chk(h === v[16], $sformatf("R3 R7 write vec %0d hit_n", i), h, v[16]);
      end else begin
        do_read(v[51:41], v[40:33], h, d, en);
        chk(h === v[16], $sformatf("R3 R4 read vec %0d hit_n", i), h, v[16]);
        chk(d === v[15:0], $sformatf("R1 R7 read vec %0d data", i), d, v[15:0]);
      end
    end

    // R12 latency: row 5 is cached now
    rfsh_n = 1; wsel = 0; addr = 11'h005; row_stb_n = 0;
    step(2);
    chk(hit_n === 1'b1, "R12 hit_n before edge-detect", hit_n, 1);
    step(1);
    chk(hit_n === 1'b0, "R12 hit_n after edge-detect", hit_n, 0);
    close_row();

    // R6 byte write gating
    do_write(11'h005, 8'd3, 16'hFFFF, 2'b11, h);
    do_write(11'h005, 8'd3, 16'h0000, 2'b01, h);
    do_read(11'h005, 8'd3, h, d, en);
    chk(d === 16'hFF00, "R6 only lane 0 written", d, 16'hFF00);

    // R5 column latch, R8 output latch, R9 output enable
    open_row(1, 0, 11'h005);
    addr = 11'd1;
    step(4);
    chk(dq_en === 1'b0, "R9 no drive while oen_n high", dq_en, 0);
    oen_n = 0;
    step(4);
    chk(dq_en === 1'b1 && dq === 16'hA1B2, "R9 drive during read", dq, 16'hA1B2);
    col_stb_n = '0;
    step(4);
    addr = 11'd2;
    step(4);
    chk(dq === 16'hA1B2, "R5 column latch holds", dq, 16'hA1B2);
    col_stb_n = '1;
    step(4);
    chk(dq === 16'hC3D4, "R5 column latch transparent", dq, 16'hC3D4);
    qhold = 1;
    step(4);
    addr = 11'd1;
    step(4);
    chk(dq === 16'hC3D4, "R8 output latch frozen", dq, 16'hC3D4);
    qhold = 0;
    step(4);
    chk(dq === 16'hA1B2, "R8 output latch transparent", dq, 16'hA1B2);
    close_row();
    chk(dq_en === 1'b0, "R9 no drive after row closes", dq_en, 0);

    // R10 deselected cycles ignored
    cs_n = 1;
    do_read(11'h009, 8'd0, h, d, en);
    chk(h === 1'b1 && en === 1'b0, "R10 deselected read", {h, en}, 2'b10);
    do_write(11'h005, 8'd3, 16'h1111, 2'b11, h);
    chk(h === 1'b1, "R10 deselected write hit_n", h, 1);
    // R2 refresh runs while deselected
    r0 = rfsh_row;
    do_refresh();
    chk(rfsh_row === r0 + 1'b1, "R2 refresh while deselected", rfsh_row, r0 + 1'b1);
    cs_n = 0;
    do_read(11'h005, 8'd3, h, d, en);
    chk(h === 1'b0, "R10 R4 tag kept after deselected read and refresh", h, 0);
    chk(d === 16'hFF00, "R10 deselected write left data", d, 16'hFF00);

    // R2 wrap
    r0 = rfsh_row;
    for (int i = 0; i < 2048; i++) do_refresh();
    chk(rfsh_row === r0, "R2 refresh counter wraps", rfsh_row, r0);
    do_read(11'h005, 8'd2, h, d, en);
    chk(h === 1'b0, "R4 tag valid after refresh sweep", h, 0);

    // R11 mid-run reset
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(2);
    chk(rfsh_row === '0 && hit_n === 1'b1, "R11 reset clears counter", rfsh_row, 0);
    do_read(11'h005, 8'd3, h, d, en);
    chk(h === 1'b1, "R11 tag invalid after reset", h, 1);
    chk(d === 16'hFF00, "R11 array kept over reset", d, 16'hFF00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule